// File: doc/BRIEF.md
# Circular and Bit-Reverse Address Generator

This block generates data-memory addresses for a signal-processing core. It holds four pointer contexts. Each context has an index (the pointer), a modifier, a buffer base and a buffer length. Every accepted access command produces one address and one new value for the selected pointer.

The step added to the pointer comes either from an offset carried in the command or from one of the modifier registers. The pointer can be used as the address before the step (post-modify) or after it (pre-modify). When the context length is non-zero, the stepped pointer wraps inside a circular buffer that may sit at any word address and have any length. A bit-reverse mode instead adds the step with its carry running from the most significant bit of a low field toward its least significant bit, which is the visiting order an in-place FFT needs.

The address leaves through a register one cycle after the command is accepted. The pointer update is written back one cycle after that. A command that reuses the same pointer in the cycle straight after its producer is held off for one cycle by a stall output.

Top module: `circ_agu`

## Requirements
- R1: After reset `addrValid` is 0 and every register of every kind reads back as 0.
- R2: A write with `regWrEn`=1 stores `regWrData` into the register chosen by `regWrKind` (0 index, 1 modifier, 2 base, 3 length) and `regWrSel`. The combinational read port returns it for the same kind and select from the next cycle.
- R3: Post-modify (`cmdPre`=0): the address equals the pointer value before the access, and the pointer becomes the updated value.
- R4: Pre-modify (`cmdPre`=1): the address equals the updated pointer value, and the pointer takes that same value.
- R5: With `cmdImm`=1 the step is `cmdOffset` and the modifier registers are ignored. With `cmdImm`=0 the step is modifier register `cmdModSel` and `cmdOffset` is ignored.
- R6: With a non-zero length and bit-reverse off, a sum pointer+step that reaches or passes base+length has length subtracted. This applies to any base, including unaligned ones, and to a step equal to the length.
- R7: With a non-zero length and bit-reverse off, a sum below base has length added. With length 0 the update is plain pointer+step.
- R8: With `cmdBitRev`=1 the low REV_BITS (default 8) bits of the pointer are added to those of the step with the carry moving from the highest bit toward bit 0. The upper pointer bits are kept, and the length is ignored.
- R9: `addrValid` rises exactly one cycle after an accepted command, and `addrSize` repeats that command's `cmdSize` (0 single, 1 dual, 2 quad word).
- R10: In the cycle after a command is accepted, a valid command using the same `cmdPtrSel` raises `stall` and is not accepted. A different `cmdPtrSel` does not stall. A stalled command proceeds in the following cycle and sees the updated pointer.
- R11: The updated pointer appears at the read port two clock edges after the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrKind | input | 2 | Register kind for write: 0 index, 1 modifier, 2 base, 3 length |
| regWrSel | input | 2 | Context number for write |
| regWrData | input | 32 | Write data |
| regRdKind | input | 2 | Register kind for read |
| regRdSel | input | 2 | Context number for read |
| regRdData | output | 32 | Read data, combinational |
| cmdValid | input | 1 | Access command present |
| cmdPre | input | 1 | 1 pre-modify, 0 post-modify |
| cmdImm | input | 1 | 1 step from cmdOffset, 0 from a modifier register |
| cmdBitRev | input | 1 | Reverse-carry pointer update |
| cmdPtrSel | input | 2 | Pointer context used |
| cmdModSel | input | 2 | Modifier register used when cmdImm is 0 |
| cmdOffset | input | 32 | Immediate step, two's complement |
| cmdSize | input | 2 | Access size code |
| stall | output | 1 | Command held off this cycle |
| addrValid | output | 1 | addrOut carries a new address |
| addrOut | output | 32 | Generated address |
| addrSize | output | 2 | Size code of that address |

## Verification
A wrong wrap comparison or a bad reverse-carry chain shows on `addrOut` one cycle after the access for pre-modify. For post-modify it shows at the read port one cycle later, or in the address of the next access to that pointer. A lost or misdirected write-back shows up as a stale address on the command that was stalled for it. A broken stall shows either as that stale address or as a missing `addrValid` pulse in the cycle after the held command. The bench therefore reads back every pointer after each access, and it runs a back-to-back pair on one pointer and on two different pointers.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    KIND_INDEX = 2'd0,
    KIND_MOD   = 2'd1,
    KIND_BASE  = 2'd2,
    KIND_LEN   = 2'd3
  } regKindT;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // latch address, size and pending pointer
    logic hostWr;   // register write port active
    logic wbWr;     // write pending pointer back into index file
  } aguStrobeT;
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl #(
  parameter int CW = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [CW-1:0]        cmdPtrSel,
  input  logic                 regWrEn,
  output logic                 stall,
  output logic                 addrValid,
  output logic [CW-1:0]        wbSel,
  output agu_pkg::aguStrobeT   strb
);
  logic wbPend;

  // hazard: pointer still in flight to the index file
  assign stall = cmdValid && wbPend && (cmdPtrSel == wbSel);

  always_comb begin
    strb.accept = cmdValid && !stall;
    strb.hostWr = regWrEn;
    strb.wbWr   = wbPend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbPend    <= 1'b0;
      wbSel     <= '0;
      addrValid <= 1'b0;
    end else begin
      wbPend    <= strb.accept;
      addrValid <= strb.accept;
      if (strb.accept) wbSel <= cmdPtrSel;
    end
  end
endmodule

// File: rtl/agu_datapath.sv
module agu_datapath #(
  parameter int AW       = 32,
  parameter int NCTX     = 4,
  parameter int REV_BITS = 8,
  localparam int CW      = $clog2(NCTX)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  agu_pkg::aguStrobeT   strb,
  input  logic [CW-1:0]        wbSel,
  input  logic [1:0]           regWrKind,
  input  logic [CW-1:0]        regWrSel,
  input  logic [AW-1:0]        regWrData,
  input  logic [1:0]           regRdKind,
  input  logic [CW-1:0]        regRdSel,
  output logic [AW-1:0]        regRdData,
  input  logic                 cmdPre,
  input  logic                 cmdImm,
  input  logic                 cmdBitRev,
  input  logic [CW-1:0]        cmdPtrSel,
  input  logic [CW-1:0]        cmdModSel,
  input  logic [AW-1:0]        cmdOffset,
  input  logic [1:0]           cmdSize,
  output logic [AW-1:0]        addrOut,
  output logic [1:0]           addrSize
);
  import agu_pkg::*;

  logic [AW-1:0] idxR  [NCTX];
  logic [AW-1:0] modR  [NCTX];
  logic [AW-1:0] baseR [NCTX];
  logic [AW-1:0] lenR  [NCTX];
  logic [AW-1:0] wbPtrR;

  function automatic logic [REV_BITS-1:0] flip(input logic [REV_BITS-1:0] v);
    for (int b = 0; b < REV_BITS; b++) flip[b] = v[REV_BITS-1-b];
  endfunction

  logic [AW-1:0]       ptr, step, base, len, sum, endAddr, circPtr, revPtr, newPtr;
  logic [REV_BITS-1:0] revSum;

  always_comb begin
    ptr     = idxR[cmdPtrSel];
    base    = baseR[cmdPtrSel];
    len     = lenR[cmdPtrSel];
    step    = cmdImm ? cmdOffset : modR[cmdModSel];
    sum     = ptr + step;
    endAddr = base + len;
    circPtr = sum;
    if (len != '0) begin
      if (sum >= endAddr)  circPtr = sum - len;
      else if (sum < base) circPtr = sum + len;
    end
    // reverse-carry add over the low field
    revSum = flip(flip(ptr[REV_BITS-1:0]) + flip(step[REV_BITS-1:0]));
    revPtr = {ptr[AW-1:REV_BITS], revSum};
    newPtr = cmdBitRev ? revPtr : circPtr;
  end

  always_comb begin
    unique case (regKindT'(regRdKind))
      KIND_INDEX: regRdData = idxR[regRdSel];
      KIND_MOD:   regRdData = modR[regRdSel];
      KIND_BASE:  regRdData = baseR[regRdSel];
      default:    regRdData = lenR[regRdSel];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NCTX; c++) begin
        idxR[c]  <= '0;
        modR[c]  <= '0;
        baseR[c] <= '0;
        lenR[c]  <= '0;
      end
      wbPtrR   <= '0;
      addrOut  <= '0;
      addrSize <= '0;
    end else begin
      if (strb.wbWr) idxR[wbSel] <= wbPtrR;
      // a host write in the same cycle takes precedence
      if (strb.hostWr) begin
        unique case (regKindT'(regWrKind))
          KIND_INDEX: idxR[regWrSel]  <= regWrData;
          KIND_MOD:   modR[regWrSel]  <= regWrData;
          KIND_BASE:  baseR[regWrSel] <= regWrData;
          default:    lenR[regWrSel]  <= regWrData;
        endcase
      end
      if (strb.accept) begin
        wbPtrR   <= newPtr;
        addrOut  <= cmdPre ? newPtr : ptr;
        addrSize <= cmdSize;
      end
    end
  end
endmodule

// File: rtl/circ_agu.sv
module circ_agu #(
  parameter int AW       = 32,
  parameter int NCTX     = 4,
  parameter int REV_BITS = 8,
  localparam int CW      = $clog2(NCTX)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [1:0]    regWrKind,
  input  logic [CW-1:0] regWrSel,
  input  logic [AW-1:0] regWrData,
  input  logic [1:0]    regRdKind,
  input  logic [CW-1:0] regRdSel,
  output logic [AW-1:0] regRdData,
  input  logic          cmdValid,
  input  logic          cmdPre,
  input  logic          cmdImm,
  input  logic          cmdBitRev,
  input  logic [CW-1:0] cmdPtrSel,
  input  logic [CW-1:0] cmdModSel,
  input  logic [AW-1:0] cmdOffset,
  input  logic [1:0]    cmdSize,
  output logic          stall,
  output logic          addrValid,
  output logic [AW-1:0] addrOut,
  output logic [1:0]    addrSize
);
  agu_pkg::aguStrobeT strb;
  logic [CW-1:0]      wbSel;

  agu_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdPtrSel(cmdPtrSel),
    .regWrEn(regWrEn), .stall(stall), .addrValid(addrValid),
    .wbSel(wbSel), .strb(strb)
  );

  agu_datapath #(.AW(AW), .NCTX(NCTX), .REV_BITS(REV_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wbSel(wbSel),
    .regWrKind(regWrKind), .regWrSel(regWrSel), .regWrData(regWrData),
    .regRdKind(regRdKind), .regRdSel(regRdSel), .regRdData(regRdData),
    .cmdPre(cmdPre), .cmdImm(cmdImm), .cmdBitRev(cmdBitRev),
    .cmdPtrSel(cmdPtrSel), .cmdModSel(cmdModSel), .cmdOffset(cmdOffset),
    .cmdSize(cmdSize), .addrOut(addrOut), .addrSize(addrSize)
  );
endmodule

// File: rtl/circ_agu_chk.sv
module circ_agu_chk #(
  parameter int SELW = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdValid,
  input logic [SELW-1:0] cmdPtrSel,
  input logic [1:0]      cmdSize,
  input logic            stall,
  input logic            addrValid,
  input logic [1:0]      addrSize
);
  // R9
  addr_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (addrValid == $past(cmdValid && !stall)));

  // R9
  size_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && addrValid) |-> (addrSize == $past(cmdSize)));

  // R10
  stall_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> cmdValid);

  // R10
  stall_after_same_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> ($past(rstN) && $past(cmdValid && !stall) && cmdPtrSel == $past(cmdPtrSel)));

  // R10
  stall_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);
endmodule

bind circ_agu circ_agu_chk #(.SELW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdPtrSel(cmdPtrSel),
  .cmdSize(cmdSize), .stall(stall), .addrValid(addrValid), .addrSize(addrSize)
);

// File: tb/sim_circ_agu.sv
module sim_circ_agu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrKind = '0, regWrSel = '0, regRdKind = '0, regRdSel = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        cmdValid = 1'b0, cmdPre = 1'b0, cmdImm = 1'b0, cmdBitRev = 1'b0;
  logic [1:0]  cmdPtrSel = '0, cmdModSel = '0, cmdSize = '0, addrSize;
  logic [31:0] cmdOffset = '0, addrOut;
  logic        stall, addrValid;

  int chkCnt = 0;
  int errCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  circ_agu u0 (.*);

  typedef struct packed {
    logic [31:0] base, len, ptr, step;
    logic        imm, pre, brev;
    logic [1:0]  size;
    logic [31:0] expAddr, expPtr;
  } vecT;

  localparam int NV = 11;
  localparam vecT VEC [NV] = '{
    '{32'h0,    32'd0,  32'h100,  32'd4,        1'b0, 1'b0, 1'b0, 2'd0, 32'h100,  32'h104},  // R3 linear
    '{32'h0,    32'd0,  32'h200,  32'd8,        1'b1, 1'b1, 1'b0, 2'd1, 32'h208,  32'h208},  // R4 R5
    '{32'h1003, 32'd10, 32'h100B, 32'd3,        1'b0, 1'b0, 1'b0, 2'd2, 32'h100B, 32'h1004}, // R6
    '{32'h1003, 32'd10, 32'h1004, 32'hFFFFFFFD, 1'b0, 1'b1, 1'b0, 2'd0, 32'h100B, 32'h100B}, // R7
    '{32'h1003, 32'd10, 32'h1005, 32'd2,        1'b1, 1'b0, 1'b0, 2'd1, 32'h1005, 32'h1007}, // no wrap
    '{32'h1003, 32'd10, 32'h100A, 32'd3,        1'b0, 1'b1, 1'b0, 2'd2, 32'h1003, 32'h1003}, // R6 exact end
    '{32'h0,    32'd0,  32'h1C0,  32'h80,       1'b0, 1'b0, 1'b1, 2'd0, 32'h1C0,  32'h120},  // R8
    '{32'h0,    32'd0,  32'h0,    32'h80,       1'b1, 1'b1, 1'b1, 2'd1, 32'h80,   32'h80},   // R8
    '{32'h1003, 32'd10, 32'h1003, 32'd10,       1'b0, 1'b0, 1'b0, 2'd2, 32'h1003, 32'h1003}, // R6 step=len
    '{32'h7FF5, 32'd7,  32'h7FFB, 32'd5,        1'b0, 1'b1, 1'b0, 2'd0, 32'h7FF9, 32'h7FF9}, // R6 unaligned
    '{32'h100,  32'd5,  32'h40,   32'h80,       1'b0, 1'b0, 1'b1, 2'd1, 32'h40,   32'hC0}    // R8 len ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] kind, input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regWrKind = kind; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic logic [31:0] rdReg(input logic [1:0] kind, input logic [1:0] sel);
    regRdKind = kind; regRdSel = sel;
    return 32'h0;
  endfunction

  task automatic rdCheck(input string req, input logic [1:0] kind, input logic [1:0] sel,
                         input logic [31:0] exp);
    logic [31:0] dummy;
    dummy = rdReg(kind, sel);
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic drive(input logic [1:0] sel, input logic [1:0] msel, input logic imm,
                       input logic pre, input logic brev, input logic [31:0] off,
                       input logic [1:0] size);
    cmdValid = 1'b1; cmdPtrSel = sel; cmdModSel = msel; cmdImm = imm;
    cmdPre = pre; cmdBitRev = brev; cmdOffset = off; cmdSize = size;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, errCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while reset is still held
    check("R1 addrValid", {31'b0, addrValid}, 32'h0);
    rstN = 1'b1;
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 4; s++) rdCheck("R1 reg", k[1:0], s[1:0], 32'h0);

    // R2 write and read back
    wrReg(2'd2, 2'd3, 32'hABCD0123);
    rdCheck("R2 base readback", 2'd2, 2'd3, 32'hABCD0123);
    rdCheck("R2 other kind untouched", 2'd3, 2'd3, 32'h0);

    // vector walk: R3..R9, R11
    for (int v = 0; v < NV; v++) begin
      logic [1:0] c;
      c = v[1:0];
      wrReg(2'd2, c, VEC[v].base);
      wrReg(2'd3, c, VEC[v].len);
      wrReg(2'd0, c, VEC[v].ptr);
      // R5 the unused step source carries a decoy value
      wrReg(2'd1, c, VEC[v].imm ? 32'h0000DEAD : VEC[v].step);
      @(negedge clk);
      drive(c, c, VEC[v].imm, VEC[v].pre, VEC[v].brev,
            VEC[v].imm ? VEC[v].step : 32'h00000777, VEC[v].size);
      @(negedge clk);
      cmdValid = 1'b0;
      check($sformatf("R9 valid v%0d", v), {31'b0, addrValid}, 32'h1);
      check($sformatf("R3/R4/R6/R7/R8 addr v%0d", v), addrOut, VEC[v].expAddr);
      check($sformatf("R9 size v%0d", v), {30'b0, addrSize}, {30'b0, VEC[v].size});
      @(negedge clk);
      check($sformatf("R9 valid drop v%0d", v), {31'b0, addrValid}, 32'h0);
      rdCheck($sformatf("R11 pointer v%0d", v), 2'd0, c, VEC[v].expPtr);
    end

    // R10 back-to-back on the same pointer
    wrReg(2'd3, 2'd0, 32'd0);
    wrReg(2'd0, 2'd0, 32'h300);
    wrReg(2'd1, 2'd0, 32'd4);
    @(negedge clk);
    drive(2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd2);
    @(negedge clk);
    #1;
    check("R10 stall same ptr", {31'b0, stall}, 32'h1);
    check("R10 first addr", addrOut, 32'h300);
    @(negedge clk);
    #1;
    check("R10 stall released", {31'b0, stall}, 32'h0);
    check("R10 held cmd not accepted", {31'b0, addrValid}, 32'h0);
    @(negedge clk);
    cmdValid = 1'b0;
    check("R10 held cmd valid", {31'b0, addrValid}, 32'h1);
    check("R10 held cmd sees update", addrOut, 32'h304);
    @(negedge clk);
    rdCheck("R10 final pointer", 2'd0, 2'd0, 32'h308);

    // R10 back-to-back on different pointers: no stall
    wrReg(2'd3, 2'd1, 32'd0);
    wrReg(2'd0, 2'd1, 32'h500);
    @(negedge clk);
    drive(2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 32'h10, 2'd0);
    @(negedge clk);
    drive(2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 32'h20, 2'd1);
    #1;
    check("R10 no stall other ptr", {31'b0, stall}, 32'h0);
    check("R10 first of pair", addrOut, 32'h308);
    @(negedge clk);
    cmdValid = 1'b0;
    check("R10 second of pair", addrOut, 32'h520);
    check("R9 second size", {30'b0, addrSize}, 32'h1);
    @(negedge clk);
    rdCheck("R11 ptr0 after pair", 2'd0, 2'd0, 32'h318);
    rdCheck("R11 ptr1 after pair", 2'd0, 2'd1, 32'h520);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, errCnt);
    $finish;
  end
endmodule